// File: doc/BRIEF.md
# Thread and Module Access Rights Checker

This unit decides, for a processor core, whether a privileged operation may proceed. It keeps the identity of the running thread and of the code module that is currently executing. Two kinds of right are checked. Generic rights (stack access, code-space access and similar coarse permissions) are bits of an effective capability word: the thread's hidden capability word combined by bitwise OR with the capability word of the active module. Specific resources are each guarded by an owner register. The top bit of the owner register says whether the rest names a thread or a module, and access is granted only to that owner.

The context changes on three events. A thread switch installs a new thread and its entry module. A module call enters another module and saves the caller's module context on an eight-deep stack. A module return pops that stack, so rights gained inside the callee never flow back to the caller, while thread rights stay in force across any depth of calls. Thread 0 is the supervisor. It passes every check and is the only thread allowed to change capability tables and owner registers. Each request is answered one cycle after it is presented.

Top module: `access_rights_unit`

## Requirements
- R1: After a synchronous active-low reset, the current thread ID, current module ID and effective capability word are all zero. All capability table entries and owner registers are zero, the context stack is empty, and rsp_valid, rsp_grant, wr_denied and ctx_fault are low.
- R2: A request with req_kind=0 asks for generic right number req_idx. The cycle after any request, rsp_valid is high and rsp_grant equals bit req_idx of eff_cap, where eff_cap is the bitwise OR of the thread capability and the module capability. rsp_valid and rsp_grant are low in the cycle after a cycle with no request.
- R3: A request with req_kind=1 asks for resource register req_idx. Bit 8 of that register's 9-bit owner selects the comparison: 0 compares bits 7:0 with the current thread ID, 1 compares them with the current module ID. Access is granted only on equality.
- R4: While the current thread ID is 0, every request is granted, whatever the capability words and owners hold.
- R5: cfg_we with cfg_sel=0 writes the thread capability table at cfg_idx, and cfg_sel=1 writes the module capability table at cfg_idx. cfg_sel=2 writes bits 8:0 of cfg_data to owner register cfg_idx (indices of 16 and above write nothing), and cfg_sel=3 writes nothing. A write takes effect only while the current thread ID is 0. From any other thread it changes nothing, and wr_denied is high in the following cycle.
- R6: ctx_op=1 (switch) loads ctx_tid as thread ID and thread-table[ctx_tid] as thread capability. It loads ctx_mid as module ID and module-table[ctx_mid] as module capability, and it empties the context stack.
- R7: ctx_op=2 (call) pushes the caller's module ID and module capability and loads ctx_mid with module-table[ctx_mid]. The thread ID and thread capability are unchanged.
- R8: ctx_op=3 (return) restores the module ID and module capability saved by the matching call, so the callee's rights are gone.
- R9: A call with eight frames already saved, or a return with none, raises ctx_fault in the next cycle and leaves the whole context unchanged. ctx_fault is low otherwise.
- R10: A request, table read or context operation in the same cycle as a write or context change sees the state as it was before that cycle's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctx_op | input | 2 | Context operation: 0 none, 1 switch, 2 call, 3 return |
| ctx_tid | input | 8 | New thread ID for a switch |
| ctx_mid | input | 8 | Entry or called module ID for a switch or call |
| req_valid | input | 1 | Permission request present |
| req_kind | input | 1 | 0 generic right, 1 guarded resource |
| req_idx | input | 4 | Right bit or resource register index |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 thread cap, 1 module cap, 2 owner, 3 nothing |
| cfg_idx | input | 8 | Table entry or owner register index |
| cfg_data | input | 16 | Capability word, or owner in bits 8:0 |
| cur_tid | output | 8 | Current thread ID |
| cur_mid | output | 8 | Current module ID |
| eff_cap | output | 16 | Effective generic rights (thread OR module) |
| rsp_valid | output | 1 | Response present, one cycle after a request |
| rsp_grant | output | 1 | Request granted |
| wr_denied | output | 1 | Previous cycle's write was refused |
| ctx_fault | output | 1 | Previous cycle's call overflowed or return underflowed |

## Verification
The properties assume that ctx_op, req_valid and cfg_we are never unknown after reset and that req_idx names an existing right or resource. They also assume that the context stack flags reflect the frames pushed since the last switch. The stimulus drives only defined encodings, keeps every request index below 16, and runs long call chains from a known switch so that both stack limits are reached on purpose. A randomized stretch mixes switches among the supervisor and two ordinary threads, calls, returns, writes and requests in the same cycles, with indices inside those bounds.

// File: rtl/acr_pkg.sv
// Shared encodings for the access rights unit.
// Assumes: users cast two-bit and one-bit port values into these types.
package acr_pkg;
    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_SWITCH = 2'd1,
        OP_CALL   = 2'd2,
        OP_RETURN = 2'd3
    } ctx_op_e;

    typedef enum logic {
        KIND_GENERIC  = 1'b0,
        KIND_RESOURCE = 1'b1
    } req_kind_e;

    typedef enum logic [1:0] {
        SEL_TCAP  = 2'd0,
        SEL_MCAP  = 2'd1,
        SEL_OWNER = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/acr_cap_table.sv
// Capability table: one capability word per identifier, written one entry at
// a time and read asynchronously by identifier.
// Assumes: write qualification (privilege) is done by the caller; a read of
// the entry being written in the same cycle returns the old value.
module acr_cap_table #(
    parameter int IDX_W = 8,
    parameter int CAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [CAP_W-1:0] wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [CAP_W-1:0] rdata
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [CAP_W-1:0] words [ENTRIES];

    // Purpose: clear all entries on reset, otherwise update the addressed one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                words[i] <= '0;
            end
        end else if (we) begin
            words[widx] <= wdata;
        end
    end

    // Purpose: asynchronous lookup for the context loader.
    always_comb begin
        rdata = words[ridx];
    end
endmodule

// File: rtl/acr_ctx_stack.sv
// Module context stack: saves caller frames on call, hands them back on
// return, and is emptied on thread switch.
// Assumes: push is never asserted when full nor pop when empty (the owner
// checks full/empty first); clear wins over push and pop.
module acr_ctx_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top_data,
    output logic         full,
    output logic         empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     frames [DEPTH];
    logic [CNT_W-1:0] count;
    logic [PTR_W-1:0] top_ptr;

    // Purpose: full/empty flags and index of the newest frame.
    always_comb begin
        full    = (count == CNT_W'(DEPTH));
        empty   = (count == '0);
        top_ptr = empty ? '0 : PTR_W'(count - 1'b1);
    end

    // Purpose: newest saved frame, valid whenever the stack is not empty.
    always_comb begin
        top_data = frames[top_ptr];
    end

    // Purpose: frame depth bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (push && !full) begin
            count <= count + 1'b1;
        end else if (pop && !empty) begin
            count <= count - 1'b1;
        end
    end

    // Purpose: store a frame at the next free slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                frames[i] <= '0;
            end
        end else if (push && !full && !clear) begin
            frames[PTR_W'(count)] <= push_data;
        end
    end
endmodule

// File: rtl/acr_owner_bank.sv
// Bank of resource owner registers with one owner matcher per register.
// The owner top bit chooses module (1) or thread (0) comparison.
// Assumes: write qualification is done by the caller; indices at or above
// NRES address nothing.
module acr_owner_bank #(
    parameter int NRES  = 16,
    parameter int ID_W  = 8,
    parameter int TID_W = 8,
    parameter int MID_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [ID_W-1:0] widx,
    input  logic [ID_W:0]   wdata,
    input  logic [TID_W-1:0] cur_tid,
    input  logic [MID_W-1:0] cur_mid,
    output logic [NRES-1:0] match
);
    localparam int OWN_W = ID_W + 1;

    logic [ID_W-1:0] tid_ext;
    logic [ID_W-1:0] mid_ext;

    // Purpose: widen both identifiers to the owner field's ID width.
    always_comb begin
        tid_ext = ID_W'(cur_tid);
        mid_ext = ID_W'(cur_mid);
    end

    for (genvar g = 0; g < NRES; g++) begin : g_res
        logic [OWN_W-1:0] owner;

        // Purpose: hold this resource's owner field.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                owner <= '0;
            end else if (we && (widx == ID_W'(g))) begin
                owner <= wdata;
            end
        end

        // Purpose: compare the owner against the identifier its top bit picks.
        always_comb begin
            match[g] = owner[ID_W] ? (owner[ID_W-1:0] == mid_ext)
                                   : (owner[ID_W-1:0] == tid_ext);
        end
    end
endmodule

// File: rtl/access_rights_unit.sv
// Access rights unit: holds the running thread and module context, answers
// generic-right and resource requests one cycle later, guards configuration
// writes with the supervisor thread (ID 0), and keeps a call/return stack so
// callee module rights do not reach the caller.
// Assumes: CAP_W >= ID_W + 1 (owner data rides in cfg_data); NRES <= 2**ID_W.
module access_rights_unit #(
    parameter int TID_W = 8,
    parameter int MID_W = 8,
    parameter int CAP_W = 16,
    parameter int NRES  = 16,
    parameter int DEPTH = 8,
    parameter int ID_W  = (TID_W > MID_W) ? TID_W : MID_W,
    parameter int IDX_W = $clog2((CAP_W > NRES) ? CAP_W : NRES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       ctx_op,
    input  logic [TID_W-1:0] ctx_tid,
    input  logic [MID_W-1:0] ctx_mid,
    input  logic             req_valid,
    input  logic             req_kind,
    input  logic [IDX_W-1:0] req_idx,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [ID_W-1:0]  cfg_idx,
    input  logic [CAP_W-1:0] cfg_data,
    output logic [TID_W-1:0] cur_tid,
    output logic [MID_W-1:0] cur_mid,
    output logic [CAP_W-1:0] eff_cap,
    output logic             rsp_valid,
    output logic             rsp_grant,
    output logic             wr_denied,
    output logic             ctx_fault
);
    import acr_pkg::*;

    localparam int FRAME_W = MID_W + CAP_W;
    localparam int OWN_W   = ID_W + 1;

    ctx_op_e          op;
    cfg_sel_e         sel;
    logic             priv;
    logic             tcap_we, mcap_we, own_we;
    logic [CAP_W-1:0] tcap_q, mcap_q;
    logic [CAP_W-1:0] tcap_rd, mcap_rd;
    logic [FRAME_W-1:0] stk_top;
    logic             stk_full, stk_empty;
    logic             do_push, do_pop, do_clear;
    logic [MID_W-1:0] stk_top_mid;
    logic [NRES-1:0]  res_match;
    logic             generic_hit, resource_hit;

    // Purpose: decode operation fields and the supervisor condition.
    always_comb begin
        op       = ctx_op_e'(ctx_op);
        sel      = cfg_sel_e'(cfg_sel);
        priv     = (cur_tid == '0);
        tcap_we  = cfg_we && priv && (sel == SEL_TCAP);
        mcap_we  = cfg_we && priv && (sel == SEL_MCAP);
        own_we   = cfg_we && priv && (sel == SEL_OWNER);
        do_clear = (op == OP_SWITCH);
        do_push  = (op == OP_CALL) && !stk_full;
        do_pop   = (op == OP_RETURN) && !stk_empty;
        stk_top_mid = stk_top[FRAME_W-1:CAP_W];
    end

    acr_cap_table #(.IDX_W(TID_W), .CAP_W(CAP_W)) u_thread_caps (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tcap_we),
        .widx  (TID_W'(cfg_idx)),
        .wdata (cfg_data),
        .ridx  (ctx_tid),
        .rdata (tcap_rd)
    );

    acr_cap_table #(.IDX_W(MID_W), .CAP_W(CAP_W)) u_module_caps (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mcap_we),
        .widx  (MID_W'(cfg_idx)),
        .wdata (cfg_data),
        .ridx  (ctx_mid),
        .rdata (mcap_rd)
    );

    acr_ctx_stack #(.DEPTH(DEPTH), .W(FRAME_W)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (do_clear),
        .push      (do_push),
        .pop       (do_pop),
        .push_data ({cur_mid, mcap_q}),
        .top_data  (stk_top),
        .full      (stk_full),
        .empty     (stk_empty)
    );

    acr_owner_bank #(.NRES(NRES), .ID_W(ID_W), .TID_W(TID_W), .MID_W(MID_W)) u_owners (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (own_we),
        .widx    (cfg_idx),
        .wdata   (cfg_data[OWN_W-1:0]),
        .cur_tid (cur_tid),
        .cur_mid (cur_mid),
        .match   (res_match)
    );

    // Purpose: thread context changes only on a switch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_tid <= '0;
            tcap_q  <= '0;
        end else if (op == OP_SWITCH) begin
            cur_tid <= ctx_tid;
            tcap_q  <= tcap_rd;
        end
    end

    // Purpose: module context follows switch, call and return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_mid <= '0;
            mcap_q  <= '0;
        end else if (op == OP_SWITCH || do_push) begin
            cur_mid <= ctx_mid;
            mcap_q  <= mcap_rd;
        end else if (do_pop) begin
            cur_mid <= stk_top_mid;
            mcap_q  <= stk_top[CAP_W-1:0];
        end
    end

    // Purpose: effective generic rights and per-request hit lookup.
    always_comb begin
        eff_cap      = tcap_q | mcap_q;
        generic_hit  = |(eff_cap & (CAP_W'(1) << req_idx));
        resource_hit = |(res_match & (NRES'(1) << req_idx));
    end

    // Purpose: registered request answer, write refusal and stack fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
            wr_denied <= 1'b0;
            ctx_fault <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_grant <= req_valid && (priv ||
                         ((req_kind_e'(req_kind) == KIND_GENERIC) ? generic_hit
                                                                   : resource_hit));
            wr_denied <= cfg_we && !priv;
            ctx_fault <= ((op == OP_CALL) && stk_full) ||
                         ((op == OP_RETURN) && stk_empty);
        end
    end
endmodule

// File: rtl/acr_checker.sv
// Protocol and policy properties for access_rights_unit, attached by bind.
// Assumes: inputs are defined after reset; stack flags come from the unit.
module acr_checker #(
    parameter int TID_W = 8,
    parameter int MID_W = 8,
    parameter int CAP_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       ctx_op,
    input logic [TID_W-1:0] ctx_tid,
    input logic             req_valid,
    input logic             cfg_we,
    input logic [TID_W-1:0] cur_tid,
    input logic [MID_W-1:0] cur_mid,
    input logic [CAP_W-1:0] tcap_q,
    input logic             rsp_valid,
    input logic             rsp_grant,
    input logic             wr_denied,
    input logic             ctx_fault,
    input logic             stk_full,
    input logic             stk_empty,
    input logic [MID_W-1:0] stk_top_mid
);
    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_grant));

    assert_supervisor_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_tid == '0) |=> rsp_grant);

    assert_write_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cur_tid != '0) |=> wr_denied);

    assert_write_accepted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we || cur_tid == '0) |=> !wr_denied);

    assert_switch_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_op == 2'd1) |=> (cur_tid == $past(ctx_tid)));

    assert_thread_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_op == 2'd2) |=> ($stable(cur_tid) && $stable(tcap_q)));

    assert_return_restores_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_op == 2'd3 && !stk_empty) |=> (cur_mid == $past(stk_top_mid)));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_op == 2'd2 && stk_full) |=> (ctx_fault && $stable(cur_mid)));

    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_op == 2'd3 && stk_empty) |=> (ctx_fault && $stable(cur_mid)));
endmodule

bind access_rights_unit acr_checker #(
    .TID_W (TID_W),
    .MID_W (MID_W),
    .CAP_W (CAP_W)
) u_acr_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctx_op      (ctx_op),
    .ctx_tid     (ctx_tid),
    .req_valid   (req_valid),
    .cfg_we      (cfg_we),
    .cur_tid     (cur_tid),
    .cur_mid     (cur_mid),
    .tcap_q      (tcap_q),
    .rsp_valid   (rsp_valid),
    .rsp_grant   (rsp_grant),
    .wr_denied   (wr_denied),
    .ctx_fault   (ctx_fault),
    .stk_full    (stk_full),
    .stk_empty   (stk_empty),
    .stk_top_mid (stk_top_mid)
);

// File: tb/access_rights_unit_bench.sv
// Bench: behavioural reference model (arrays and a queue) stepped once per
// clock and compared against every output after each edge.
module access_rights_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ctx_op = 2'd0;
    logic [7:0]  ctx_tid = '0;
    logic [7:0]  ctx_mid = '0;
    logic        req_valid = 1'b0;
    logic        req_kind = 1'b0;
    logic [3:0]  req_idx = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd3;
    logic [7:0]  cfg_idx = '0;
    logic [15:0] cfg_data = '0;
    logic [7:0]  cur_tid, cur_mid;
    logic [15:0] eff_cap;
    logic        rsp_valid, rsp_grant, wr_denied, ctx_fault;

    int total = 0;
    int bad = 0;
    bit reported = 0;

    // reference model state
    logic [15:0] m_tt [256];
    logic [15:0] m_mt [256];
    logic [8:0]  m_own [16];
    logic [23:0] m_stk [$];
    logic [7:0]  m_tid, m_mid;
    logic [15:0] m_tcap, m_mcap;
    logic        e_rv, e_grant, e_wd, e_fault;

    always #5ns clk = ~clk;

    access_rights_unit u_access_rights_unit (
        .clk(clk), .rst_n(rst_n), .ctx_op(ctx_op), .ctx_tid(ctx_tid), .ctx_mid(ctx_mid),
        .req_valid(req_valid), .req_kind(req_kind), .req_idx(req_idx),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .cur_tid(cur_tid), .cur_mid(cur_mid), .eff_cap(eff_cap),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .wr_denied(wr_denied),
        .ctx_fault(ctx_fault)
    );

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
        end
    endtask

    task automatic check(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        check(tag, "cur_tid", int'(cur_tid), int'(m_tid));
        check(tag, "cur_mid", int'(cur_mid), int'(m_mid));
        check(tag, "eff_cap", int'(eff_cap), int'(m_tcap | m_mcap));
        check(tag, "rsp_valid", int'(rsp_valid), int'(e_rv));
        check(tag, "rsp_grant", int'(rsp_grant), int'(e_grant));
        check(tag, "wr_denied", int'(wr_denied), int'(e_wd));
        check(tag, "ctx_fault", int'(ctx_fault), int'(e_fault));
    endtask

    task automatic model_reset();
        for (int i = 0; i < 256; i++) begin
            m_tt[i] = '0;
            m_mt[i] = '0;
        end
        for (int i = 0; i < 16; i++) m_own[i] = '0;
        m_stk.delete();
        m_tid = '0; m_mid = '0; m_tcap = '0; m_mcap = '0;
        e_rv = 0; e_grant = 0; e_wd = 0; e_fault = 0;
    endtask

    // One clock: drive, predict from pre-edge model state, then compare.
    task automatic cyc(input logic [1:0] op, input logic [7:0] tid, input logic [7:0] mid,
                       input logic rv, input logic kind, input logic [3:0] idx,
                       input logic we, input logic [1:0] sel, input logic [7:0] cidx,
                       input logic [15:0] data, input string tag);
        logic [15:0] eff, tt_rd, mt_rd;
        logic        priv, hit;
        ctx_op = op; ctx_tid = tid; ctx_mid = mid;
        req_valid = rv; req_kind = kind; req_idx = idx;
        cfg_we = we; cfg_sel = sel; cfg_idx = cidx; cfg_data = data;
        priv = (m_tid == 0);
        eff = m_tcap | m_mcap;
        if (kind == 1'b0) hit = eff[idx];
        else hit = m_own[idx][8] ? (m_own[idx][7:0] == m_mid) : (m_own[idx][7:0] == m_tid);
        e_rv = rv;
        e_grant = rv && (priv || hit);
        e_wd = we && !priv;
        e_fault = 0;
        tt_rd = m_tt[tid];
        mt_rd = m_mt[mid];
        if (we && priv) begin
            case (sel)
                2'd0: m_tt[cidx] = data;
                2'd1: m_mt[cidx] = data;
                2'd2: if (cidx < 16) m_own[cidx[3:0]] = data[8:0];
                default: ;
            endcase
        end
        case (op)
            2'd1: begin
                m_tid = tid; m_tcap = tt_rd; m_mid = mid; m_mcap = mt_rd;
                m_stk.delete();
            end
            2'd2: begin
                if (m_stk.size() == 8) e_fault = 1;
                else begin
                    m_stk.push_back({m_mid, m_mcap});
                    m_mid = mid; m_mcap = mt_rd;
                end
            end
            2'd3: begin
                if (m_stk.size() == 0) e_fault = 1;
                else {m_mid, m_mcap} = m_stk.pop_back();
            end
            default: ;
        endcase
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic idle(string tag);
        cyc(2'd0, 8'd0, 8'd0, 0, 0, 4'd0, 0, 2'd3, 8'd0, 16'd0, tag);
    endtask
    task automatic req(logic kind, logic [3:0] idx, string tag);
        cyc(2'd0, 8'd0, 8'd0, 1, kind, idx, 0, 2'd3, 8'd0, 16'd0, tag);
    endtask
    task automatic wr(logic [1:0] sel, logic [7:0] idx, logic [15:0] data, string tag);
        cyc(2'd0, 8'd0, 8'd0, 0, 0, 4'd0, 1, sel, idx, data, tag);
    endtask
    task automatic ctx(logic [1:0] op, logic [7:0] tid, logic [7:0] mid, string tag);
        cyc(op, tid, mid, 0, 0, 4'd0, 0, 2'd3, 8'd0, 16'd0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;
        idle("R1");

        // supervisor sets up tables and owners (R5)
        wr(2'd0, 8'd5, 16'h0011, "R5");
        wr(2'd0, 8'd7, 16'h0100, "R5");
        wr(2'd1, 8'd3, 16'h0202, "R5");
        wr(2'd1, 8'd9, 16'h4000, "R5");
        wr(2'd2, 8'd2, 16'h0005, "R5");
        wr(2'd2, 8'd4, 16'h0109, "R5");
        wr(2'd2, 8'd6, 16'h0103, "R5");
        wr(2'd2, 8'd20, 16'h0000, "R5");
        // supervisor passes everything (R4)
        req(1, 4'd4, "R4");
        req(0, 4'd15, "R4");

        // ordinary thread 5 entering module 3 (R6)
        ctx(2'd1, 8'd5, 8'd3, "R6");
        req(0, 4'd0, "R2");
        req(0, 4'd9, "R2");
        req(0, 4'd2, "R2");
        req(0, 4'd4, "R2");
        req(1, 4'd2, "R3");
        req(1, 4'd6, "R3");
        req(1, 4'd4, "R3");
        req(1, 4'd7, "R3");
        // refused write, then prove owner 4 untouched (R5)
        wr(2'd2, 8'd4, 16'h0005, "R5");
        req(1, 4'd4, "R5");
        wr(2'd1, 8'd3, 16'hFFFF, "R5");
        req(0, 4'd3, "R5");

        // call into module 9: thread rights stay (R7)
        ctx(2'd2, 8'd0, 8'd9, "R7");
        req(1, 4'd4, "R7");
        req(1, 4'd2, "R7");
        req(0, 4'd0, "R7");
        req(0, 4'd9, "R7");
        // return: callee rights gone (R8)
        ctx(2'd3, 8'd0, 8'd0, "R8");
        req(1, 4'd4, "R8");
        req(0, 4'd14, "R8");

        // same-cycle call and request see the old module (R10)
        cyc(2'd2, 8'd0, 8'd9, 1, 1, 4'd4, 0, 2'd3, 8'd0, 16'd0, "R10");
        req(1, 4'd4, "R10");
        ctx(2'd3, 8'd0, 8'd0, "R8");

        // underflow on empty stack (R9)
        ctx(2'd3, 8'd0, 8'd0, "R9");
        req(1, 4'd6, "R9");
        // fill to eight, then overflow (R9)
        for (int i = 0; i < 8; i++) ctx(2'd2, 8'd0, 8'(10 + i), "R9");
        ctx(2'd2, 8'd0, 8'd9, "R9");
        for (int i = 0; i < 8; i++) ctx(2'd3, 8'd0, 8'd0, "R8");
        ctx(2'd3, 8'd0, 8'd0, "R9");

        // back to supervisor; same-cycle switch and write uses old thread (R10)
        ctx(2'd1, 8'd0, 8'd0, "R6");
        cyc(2'd1, 8'd7, 8'd3, 0, 0, 4'd0, 1, 2'd0, 8'd7, 16'h0800, "R10");
        req(0, 4'd8, "R10");
        ctx(2'd1, 8'd0, 8'd0, "R6");
        ctx(2'd1, 8'd7, 8'd9, "R6");
        req(0, 4'd11, "R2");
        ctx(2'd1, 8'd0, 8'd0, "R6");

        // randomized mix
        for (int n = 0; n < 600; n++) begin
            logic [1:0] op;
            logic [7:0] tid;
            int pick;
            pick = $urandom_range(0, 9);
            op = (pick < 4) ? 2'd0 : (pick < 5) ? 2'd1 : (pick < 8) ? 2'd2 : 2'd3;
            case ($urandom_range(0, 2))
                0: tid = 8'd0;
                1: tid = 8'd5;
                default: tid = 8'd7;
            endcase
            cyc(op, tid, 8'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)),
                1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                8'($urandom_range(0, 17)), 16'($urandom), "R10");
        end

        summary();
        $finish;
    end
endmodule